// File: doc/BRIEF.md
# Second-Order Feed-Forward Delta-Sigma Modulator

This block is a fixed-point digital model of a second-order delta-sigma modulator. It takes a stream of signed 16-bit samples and returns one output bit per sample. Over time, the fraction of ones in the output follows the input level. Inside, two saturating integrators run in cascade. The comparator sees the second integrator, plus the input, plus twice the first integrator. That weighting gives a noise transfer of (1 - z^-1)^2 and a unity signal transfer. A 1-bit feedback DAC subtracts plus or minus the reference from the input. The value it subtracts comes from the bit decided for a sample, and it takes effect in the integrator state that the next sample sees.

Input codes are scaled against a reference of 32768 LSBs. Linear full scale, ±26214, is therefore 0.8 of the reference. The overload threshold, ±32767, is 1.25 times linear full scale. When the input reaches or passes that threshold, the output is pinned to a constant level. One inverted marker bit is forced into the stream every 128 samples, so a downstream monitor can tell a live, overloaded channel from a dead one.

Both sides of the block are valid/ready streams. A sample is taken on any clock edge where `s_valid` and `s_ready` are both high. The result bit is held in a single output register. `s_ready` is high whenever that register is empty or is being read in the same cycle. A bit that has been presented stays unchanged until the consumer takes it. The modulator state advances only when a sample is taken, so stalls on either side have no effect on the bit sequence.

Top module: `dsm2_ff_mod`

## Requirements
- R1: A synchronous active-high `rst` clears both integrators, the marker counter and the overload state. After reset, `m_valid` is 0 and `s_ready` is 1.
- R2: A sample is accepted when `s_valid && s_ready`. `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_bit` keeps its value. The block produces exactly one output bit per accepted sample, in order.
- R3: For each sample, the comparator value is q = x + 2*i1 + i2, using the integrator values from before the update. The natural bit is 1 when q >= 0. The DAC value is +32768 if the emitted bit is 1 and -32768 if it is 0. The updates are i1 <= sat1(i1 + x - dac) and i2 <= sat2(i2 + i1).
- R4: A constant zero input gives between 485 and 515 ones over a 1000-sample window, taken after the first 24 samples following reset.
- R5: An input of +26214 gives 875 to 925 ones over such a window. An input of -26214 gives 75 to 125 ones.
- R6: An input at or above +32767 is in the positive overload region. There the output is 1, except that sample 127, 255, ... of the run (counting from 0) is forced to 0.
- R7: An input at or below -32767 is in the negative overload region. There the output is 0, except that sample 127, 255, ... of the run is forced to 1.
- R8: The 7-bit marker counter advances on every accepted sample. It restarts at 0 on any sample that enters an overload region from the linear region or from the opposite overload region.
- R9: i1 saturates at ±2^20 and i2 at ±2^22; neither wraps. After 2000 overloaded samples, a zero input brings the density back into the R4 band within 1500 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample this cycle |
| s_data | input | 16 | Signed input sample, two's complement |
| m_valid | output | 1 | Output bit valid |
| m_ready | input | 1 | Consumer takes the output bit this cycle |
| m_bit | output | 1 | Modulator output bit |

## Verification
Several properties are checked on every clock edge: the output hold under back-pressure, readiness while the output register is empty, the saturation bounds of both integrators, and the forced levels and marker positions for overloaded samples. The ones-density figures and the recovery after saturation are statistical. Only the bench's long constant-input scenarios can show them, using ones counts taken from the ports, alongside a bit-exact behavioural model that is compared on every transfer. The bench also covers counter restart on re-entry and on a direct change of polarity, and ordering under random-looking stalls on both sides.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic [1:0] {
    REG_LIN = 2'd0,
    REG_POS = 2'd1,
    REG_NEG = 2'd2
  } clip_region_t;
endpackage

// File: rtl/dsm_sat_integ.sv
module dsm_sat_integ #(
  parameter int ACC_W = 24,
  parameter int LIM   = 1 << 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] addend,
  output logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W:0] HI = (ACC_W+1)'(LIM);
  localparam logic signed [ACC_W:0] LO = -HI;

  logic signed [ACC_W:0] sum;
  assign sum = $signed({acc[ACC_W-1], acc}) + $signed({addend[ACC_W-1], addend});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      if (sum > HI)      acc <= HI[ACC_W-1:0];
      else if (sum < LO) acc <= LO[ACC_W-1:0];
      else               acc <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/dsm_ff_quant.sv
module dsm_ff_quant #(
  parameter int ACC_W = 24
) (
  input  logic signed [ACC_W-1:0] x,
  input  logic signed [ACC_W-1:0] i1,
  input  logic signed [ACC_W-1:0] i2,
  output logic                    nat_bit
);
  localparam int QW = ACC_W + 2;
  logic signed [QW-1:0] q;

  assign q       = QW'(x) + (QW'(i1) <<< 1) + QW'(i2);
  assign nat_bit = ~q[QW-1];
endmodule

// File: rtl/dsm_clip_marker.sv
module dsm_clip_marker
  import dsm_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int MARK_W  = 7,
  parameter int CLIP_TH = 32767
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [IN_W-1:0] x,
  input  logic                   nat_bit,
  output logic                   emit_bit
);
  localparam logic signed [IN_W:0] TH_P = (IN_W+1)'(CLIP_TH);
  localparam logic signed [IN_W:0] TH_N = -TH_P;

  logic signed [IN_W:0] xw;
  clip_region_t         region_now, region_q;
  logic [MARK_W-1:0]    cnt_q, idx;
  logic                 entering, marker;

  assign xw = (IN_W+1)'(x);

  always_comb begin
    if (xw >= TH_P)      region_now = REG_POS;
    else if (xw <= TH_N) region_now = REG_NEG;
    else                 region_now = REG_LIN;
  end

  assign entering = (region_now != REG_LIN) && (region_now != region_q);
  assign idx      = entering ? '0 : cnt_q;
  assign marker   = (region_now != REG_LIN) && (idx == '1);

  always_comb begin
    case (region_now)
      REG_POS: emit_bit = ~marker;
      REG_NEG: emit_bit = marker;
      default: emit_bit = nat_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= REG_LIN;
      cnt_q    <= '0;
    end else if (en) begin
      region_q <= region_now;
      cnt_q    <= idx + MARK_W'(1);
    end
  end
endmodule

// File: rtl/dsm2_ff_mod.sv
module dsm2_ff_mod #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 24,
  parameter int MARK_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic signed [IN_W-1:0] s_data,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic                   m_bit
);
  localparam int REF_MAG = 1 << (IN_W - 1);
  localparam int LIN_FS  = (REF_MAG * 4) / 5;
  localparam int CLIP_TH = LIN_FS + LIN_FS / 4;
  localparam int I1_LIM  = 1 << (ACC_W - 4);
  localparam int I2_LIM  = 1 << (ACC_W - 2);
  localparam logic signed [ACC_W-1:0] DAC_P = ACC_W'(REF_MAG);
  localparam logic signed [ACC_W-1:0] DAC_N = -DAC_P;

  logic                    fire, nat_bit, emit_bit;
  logic signed [ACC_W-1:0] x_ext, dac_val, i1_acc, i2_acc;
  logic signed [ACC_W-1:0] integ_in  [2];
  logic signed [ACC_W-1:0] integ_out [2];

  // stream handshake: one output slot
  assign s_ready = !m_valid || m_ready;
  assign fire    = s_valid && s_ready;

  // input scaling: codes already in reference LSBs, widen with sign
  assign x_ext   = ACC_W'(s_data);
  assign dac_val = emit_bit ? DAC_P : DAC_N;

  assign integ_in[0] = x_ext - dac_val;
  assign integ_in[1] = integ_out[0];
  assign i1_acc      = integ_out[0];
  assign i2_acc      = integ_out[1];

  for (genvar s = 0; s < 2; s++) begin : g_stage
    localparam int STAGE_LIM = (s == 0) ? I1_LIM : I2_LIM;
    dsm_sat_integ #(.ACC_W(ACC_W), .LIM(STAGE_LIM)) u_integ (
      .clk    (clk),
      .rst    (rst),
      .en     (fire),
      .addend (integ_in[s]),
      .acc    (integ_out[s])
    );
  end

  dsm_ff_quant #(.ACC_W(ACC_W)) u_quant (
    .x       (x_ext),
    .i1      (i1_acc),
    .i2      (i2_acc),
    .nat_bit (nat_bit)
  );

  dsm_clip_marker #(.IN_W(IN_W), .MARK_W(MARK_W), .CLIP_TH(CLIP_TH)) u_clip (
    .clk      (clk),
    .rst      (rst),
    .en       (fire),
    .x        (s_data),
    .nat_bit  (nat_bit),
    .emit_bit (emit_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_bit   <= 1'b0;
    end else if (fire) begin
      m_valid <= 1'b1;
      m_bit   <= emit_bit;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dsm2_ff_chk.sv
module dsm2_ff_chk #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 24,
  parameter int MARK_W = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    s_valid,
  input logic                    s_ready,
  input logic signed [IN_W-1:0]  s_data,
  input logic                    m_valid,
  input logic                    m_ready,
  input logic                    m_bit,
  input logic signed [ACC_W-1:0] i1,
  input logic signed [ACC_W-1:0] i2
);
  localparam int REF_MAG = 1 << (IN_W - 1);
  localparam int CLIP_TH = (REF_MAG * 4) / 5 + ((REF_MAG * 4) / 5) / 4;
  localparam logic signed [IN_W:0]    TP  = (IN_W+1)'(CLIP_TH);
  localparam logic signed [IN_W:0]    TN  = -TP;
  localparam logic signed [ACC_W-1:0] L1P = ACC_W'(1 << (ACC_W - 4));
  localparam logic signed [ACC_W-1:0] L1N = -L1P;
  localparam logic signed [ACC_W-1:0] L2P = ACC_W'(1 << (ACC_W - 2));
  localparam logic signed [ACC_W-1:0] L2N = -L2P;

  logic [1:0]        ck_reg, now_reg;
  logic [MARK_W-1:0] ck_idx, use_idx;
  logic              ck_chk, ck_exp, rst_q, take;
  logic signed [IN_W:0] xw;

  assign take    = s_valid && s_ready;
  assign xw      = (IN_W+1)'(s_data);
  assign now_reg = (xw >= TP) ? 2'd1 : ((xw <= TN) ? 2'd2 : 2'd0);
  assign use_idx = (now_reg != 2'd0 && now_reg != ck_reg) ? '0 : ck_idx;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      ck_reg <= 2'd0;
      ck_idx <= '0;
      ck_chk <= 1'b0;
      ck_exp <= 1'b0;
    end else if (take) begin
      ck_reg <= now_reg;
      ck_idx <= use_idx + MARK_W'(1);
      ck_chk <= (now_reg != 2'd0);
      ck_exp <= (now_reg == 2'd1) ? (use_idx != '1) : (use_idx == '1);
    end
    // R1: the cycle after reset shows an empty output register
    if (rst_q) a_reset_r1: assert (!m_valid);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_bit)));

  p_ready_r2: assert property (@(posedge clk) disable iff (rst)
    !m_valid |-> s_ready);

  p_i1_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (i1 <= L1P) && (i1 >= L1N));

  p_i2_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (i2 <= L2P) && (i2 >= L2N));

  // R6 and R7: forced level and marker positions in overload
  p_clip_level_r6: assert property (@(posedge clk) disable iff (rst)
    (ck_chk && m_valid) |-> (m_bit == ck_exp));
endmodule

bind dsm2_ff_mod dsm2_ff_chk #(.IN_W(IN_W), .ACC_W(ACC_W), .MARK_W(MARK_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_data  (s_data),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_bit   (m_bit),
  .i1      (i1_acc),
  .i2      (i2_acc)
);

// File: tb/dsm2_ff_mod_test.sv
module dsm2_ff_mod_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic m_ready = 1'b1;
  logic signed [15:0] s_data = '0;
  logic s_ready, m_valid, m_bit;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit stall_on = 1'b0;
  bit hold_pending = 1'b0;
  bit hold_bit = 1'b0;
  bit exp_q[$];
  bit got_q[$];
  longint mi1, mi2;
  int mreg, midx;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsm2_ff_mod uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic longint clampv(input longint v, input longint lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // behavioural reference of R3, R6, R7, R8, R9
  task automatic model_step(input longint x, output bit b);
    longint q, dac, n1, n2;
    int now_r, idx;
    bit mark;
    q = x + 2 * mi1 + mi2;
    now_r = (x >= 32767) ? 1 : ((x <= -32767) ? 2 : 0);
    idx = (now_r != 0 && now_r != mreg) ? 0 : midx;
    mark = (now_r != 0) && (idx == 127);
    if (now_r == 1)      b = !mark;
    else if (now_r == 2) b = mark;
    else                 b = (q >= 0);
    dac = b ? 32768 : -32768;
    n1 = clampv(mi1 + x - dac, 64'sd1 << 20);
    n2 = clampv(mi2 + mi1, 64'sd1 << 22);
    mi1 = n1;
    mi2 = n2;
    mreg = now_r;
    midx = (idx + 1) % 128;
  endtask

  task automatic tick(input bit v, input int d, output bit took);
    bit eb, mb;
    @(negedge clk);
    s_valid = v;
    s_data  = 16'(d);
    m_ready = stall_on ? (cyc % 5 != 1) : 1'b1;
    #1;
    if (hold_pending)
      check(m_valid && (m_bit == hold_bit), "R2", "held bit under back-pressure",
            longint'(m_bit), longint'(hold_bit));
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "output without accepted sample", 1, 0);
      end else begin
        eb = exp_q.pop_front();
        mb = m_bit;
        check(mb == eb, "R3", "bit versus reference", longint'(mb), longint'(eb));
        got_q.push_back(mb);
      end
    end
    hold_pending = m_valid && !m_ready;
    hold_bit = m_bit;
    took = v && s_ready;
    if (took) begin
      model_step(longint'(d), eb);
      exp_q.push_back(eb);
    end
  endtask

  task automatic feed(input int x, input int n);
    int k;
    bit t;
    k = 0;
    while (k < n) begin
      tick(!(stall_on && (cyc % 7 == 3)), x, t);
      if (t) k++;
    end
  endtask

  task automatic drain();
    bit t;
    while (exp_q.size() > 0) tick(1'b0, 0, t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    s_valid = 1'b0;
    m_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mi1 = 0; mi2 = 0; mreg = 0; midx = 0;
    exp_q.delete();
    got_q.delete();
    hold_pending = 1'b0;
    #1;
    check(m_valid == 1'b0, "R1", "m_valid after reset", longint'(m_valid), 0);
    check(s_ready == 1'b1, "R1", "s_ready after reset", longint'(s_ready), 1);
  endtask

  function automatic int ones_in(input int from, input int n);
    int c = 0;
    for (int k = from; k < from + n; k++) if (got_q[k]) c++;
    return c;
  endfunction

  task automatic density(input int x, input int lo, input int hi, input string req);
    int c;
    do_reset();
    feed(x, 1024);
    drain();
    c = ones_in(24, 1000);
    check(c >= lo && c <= hi, req, "ones in 1000-sample window", c, (lo + hi) / 2);
  endtask

  // run of overload samples starting at index 'from', polarity pos
  task automatic marker_run(input int from, input int n, input bit pos, input string req);
    bit e;
    for (int k = 0; k < n; k++) begin
      e = ((k % 128) == 127) ? !pos : pos;
      check(got_q[from + k] == e, req, $sformatf("overload bit %0d", k),
            longint'(got_q[from + k]), longint'(e));
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    tests++;
    fails++;
    $display("FAIL watchdog expired: got %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();

    // R4 zero input with stalls on both sides (R2 ordering via the reference)
    stall_on = 1'b1;
    density(0, 485, 515, "R4");
    // R5 linear full scale both polarities
    density(26214, 875, 925, "R5");
    density(-26214, 75, 125, "R5");

    // R6 positive overload at the exact threshold
    do_reset();
    feed(32767, 300);
    drain();
    marker_run(0, 300, 1'b1, "R6");

    // R7 negative overload at the exact threshold
    do_reset();
    feed(-32767, 300);
    drain();
    marker_run(0, 300, 1'b0, "R7");

    // R8 restart after a linear sample
    do_reset();
    feed(32767, 60);
    feed(0, 1);
    feed(32767, 200);
    drain();
    marker_run(0, 60, 1'b1, "R8");
    marker_run(61, 200, 1'b1, "R8");

    // R8 restart on a direct polarity change
    do_reset();
    feed(32767, 60);
    feed(-32768, 200);
    drain();
    marker_run(60, 200, 1'b0, "R8");

    // R9 saturation then recovery at zero input
    stall_on = 1'b0;
    do_reset();
    feed(32767, 2000);
    feed(0, 1500);
    drain();
    begin
      int c;
      c = ones_in(2500, 1000);
      check(c >= 485 && c <= 515, "R9", "density after saturation", c, 500);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule